// File: doc/BRIEF.md
# Pulse Width Symbol Recovery

This block turns an asynchronous demodulated bit stream into a stream of symbols without a recovered bit clock. The raw line is brought into the clock domain by a two-flop synchroniser. The length of each high run and each low run is then timed in prescaled ticks by a pair of saturating counters, one for each level. When the level changes, the finished run length is rounded to a whole number of symbol durations. That many symbols of the run's level are then sent out on a valid/ready port, one per accepted cycle.

Software sets the tick prescaler, the symbol duration in ticks and a ceiling on symbols per run. The quotient is formed by a serial divider, so a run is turned into symbols in a few tens of cycles. This is far shorter than one symbol at 500 kbaud with a 250 MHz system clock. Up to three finished runs can wait while the consumer stalls the output.

Top module: `pw_symbol_rx`

## Requirements
- R1: While rst_ni is low and after its release, sym_valid_o is low until a run has been measured.
- R2: A run of N clock cycles on line_i counts as floor(N/(prescale_i+1)) ticks, with high runs and low runs timed by separate counters.
- R3: A tick count that reaches 65535 (all ones) saturates instead of wrapping, and the run emits exactly max_syms_i symbols.
- R4: The symbol count is floor((ticks + floor(sym_dur_i/2)) / sym_dur_i), so a half symbol rounds up.
- R5: A run whose rounded count is zero still emits one symbol.
- R6: A count above max_syms_i is cut to max_syms_i, and sym_dur_i of zero gives max_syms_i symbols.
- R7: Symbols leave in the order their runs ended, and sym_data_o carries the run level (1 for high, 0 for low).
- R8: While sym_valid_o is high and sym_ready_i is low, sym_valid_o stays high and sym_data_o holds its value.
- R9: Up to three finished runs are kept while the output is stalled. A run that ends while all three places are full is dropped, and the runs already kept are not affected.
- R10: While enable_i is low nothing is measured. After enable_i rises, the run in progress and the edge that ends it produce no symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Measurement enable |
| line_i | input | 1 | Raw asynchronous demodulated line |
| prescale_i | input | 8 | Tick prescaler; a tick is prescale_i+1 cycles |
| sym_dur_i | input | 16 | Symbol duration in ticks |
| max_syms_i | input | 8 | Symbol count used on overflow and as a ceiling; must be non-zero |
| sym_valid_o | output | 1 | A symbol is offered |
| sym_data_o | output | 1 | Level of the offered symbol |
| sym_ready_i | input | 1 | Consumer accepts the symbol |

## Verification
The main path is driven with single runs of chosen length under several prescaler and duration settings. These runs separate exact multiples, lengths just under a half symbol and exactly at a half symbol, and prescaler truncation of partial ticks. Runs far longer or far shorter than one symbol, and a zero duration, show the ceiling apart from the minimum of one. A run of 70000 cycles is sized so that a wrapped counter would give 4 symbols while saturation gives the ceiling. A mixed high/low sequence checks ordering. A stalled consumer facing four runs shows both the three-run buffering and the dropping of the fourth.

// File: rtl/pwsr_pkg.sv
`timescale 1ns/1ps
package pwsr_pkg;
  typedef enum logic [1:0] {
    DIV_IDLE = 2'd0,
    DIV_BUSY = 2'd1,
    DIV_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/pwsr_sync.sv
`timescale 1ns/1ps
module pwsr_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pwsr_run_timer.sv
`timescale 1ns/1ps
module pwsr_run_timer #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!active_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_q == prescale_i) begin
      pre_q <= '0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;  // saturate, never wrap
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwsr_div.sv
`timescale 1ns/1ps
module pwsr_div
  import pwsr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W:0]   num_i,
  input  logic [CNT_W-1:0] den_i,
  input  logic             lvl_i,
  input  logic             ovf_i,
  input  logic             take_i,
  output logic             idle_o,
  output logic             done_o,
  output logic [CNT_W:0]   quo_o,
  output logic             lvl_o,
  output logic             ovf_o
);
  localparam int NUM_W  = CNT_W + 1;
  localparam int STEP_W = $clog2(NUM_W + 1);

  div_state_e        st_q;
  logic [NUM_W-1:0]  num_q;   // dividend shifts out, quotient shifts in
  logic [NUM_W-1:0]  rem_q;
  logic [CNT_W-1:0]  den_q;
  logic [STEP_W-1:0] step_q;
  logic              lvl_q, ovf_q;

  logic [NUM_W:0] rem_sh, rem_sub;
  logic           q_bit;

  always_comb begin
    rem_sh  = {rem_q, num_q[NUM_W-1]};
    q_bit   = rem_sh >= (NUM_W+1)'(den_q);  // zero divisor yields all ones
    rem_sub = rem_sh - (NUM_W+1)'(den_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= DIV_IDLE;
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      step_q <= '0;
      lvl_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      unique case (st_q)
        DIV_IDLE: if (start_i) begin
          num_q  <= num_i;
          den_q  <= den_i;
          rem_q  <= '0;
          step_q <= STEP_W'(NUM_W);
          lvl_q  <= lvl_i;
          ovf_q  <= ovf_i;
          st_q   <= DIV_BUSY;
        end
        DIV_BUSY: begin
          rem_q  <= NUM_W'(q_bit ? rem_sub : rem_sh);
          num_q  <= {num_q[NUM_W-2:0], q_bit};
          step_q <= step_q - 1'b1;
          if (step_q == STEP_W'(1)) st_q <= DIV_DONE;
        end
        DIV_DONE: if (take_i) st_q <= DIV_IDLE;
        default: st_q <= DIV_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == DIV_IDLE);
  assign done_o = (st_q == DIV_DONE);
  assign quo_o  = num_q;
  assign lvl_o  = lvl_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/pwsr_expander.sv
`timescale 1ns/1ps
module pwsr_expander #(
  parameter int CNT_W = 16,
  parameter int SYM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [CNT_W:0]   quo_i,
  input  logic             ovf_i,
  input  logic             lvl_i,
  input  logic [SYM_W-1:0] max_i,
  output logic             valid_o,
  output logic             data_o,
  input  logic             ready_i
);
  localparam int NUM_W = CNT_W + 1;

  logic [SYM_W-1:0] left_q;
  logic             lvl_q;
  logic [SYM_W-1:0] load_cnt;

  always_comb begin
    if (ovf_i || quo_i > NUM_W'(max_i)) load_cnt = max_i;
    else if (quo_i == '0)                load_cnt = SYM_W'(1);
    else                                 load_cnt = quo_i[SYM_W-1:0];
  end

  assign in_ready_o = (left_q == '0);
  assign valid_o    = (left_q != '0);
  assign data_o     = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      lvl_q  <= 1'b0;
    end else if (in_ready_o) begin
      if (in_valid_i) begin
        left_q <= load_cnt;
        lvl_q  <= lvl_i;
      end
    end else if (ready_i) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/pw_symbol_rx.sv
`timescale 1ns/1ps
module pw_symbol_rx #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 16,
  parameter int SYM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             line_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [CNT_W-1:0] sym_dur_i,
  input  logic [SYM_W-1:0] max_syms_i,
  output logic             sym_valid_o,
  output logic             sym_data_o,
  input  logic             sym_ready_i
);
  localparam int               NUM_W   = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lvl_sync, lvl_last_q, armed_q, run_edge, capture;
  logic [CNT_W-1:0] run_cnt [2];
  logic [CNT_W-1:0] hold_len;
  logic             hold_vld, hold_lvl, hold_ovf, hold_take;
  logic [NUM_W-1:0] div_num, div_quo;
  logic             div_idle, div_done, div_lvl, div_ovf, div_take, exp_ready;

  pwsr_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (lvl_sync)
  );

  // One counter per level; each clears while its level is absent.
  for (genvar l = 0; l < 2; l++) begin : g_timer
    pwsr_run_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .active_i  (enable_i && (lvl_sync == 1'(l))),
      .prescale_i(prescale_i),
      .cnt_o     (run_cnt[l])
    );
  end

  assign run_edge = enable_i && (lvl_sync != lvl_last_q);
  assign capture  = run_edge && armed_q && !hold_vld;
  assign hold_take = hold_vld && div_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_last_q <= 1'b0;
      armed_q    <= 1'b0;
      hold_vld   <= 1'b0;
      hold_len   <= '0;
      hold_lvl   <= 1'b0;
      hold_ovf   <= 1'b0;
    end else begin
      lvl_last_q <= lvl_sync;
      if (!enable_i)     armed_q <= 1'b0;
      else if (run_edge) armed_q <= 1'b1;  // first run after enable is partial
      if (capture) begin
        hold_vld <= 1'b1;
        hold_len <= run_cnt[lvl_last_q];
        hold_lvl <= lvl_last_q;
        hold_ovf <= (run_cnt[lvl_last_q] == CNT_MAX);
      end else if (hold_take) begin
        hold_vld <= 1'b0;
      end
    end
  end

  // Round to nearest: add half a symbol before dividing.
  assign div_num  = NUM_W'(hold_len) + NUM_W'(sym_dur_i >> 1);
  assign div_take = div_done && exp_ready;

  pwsr_div #(.CNT_W(CNT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(hold_take),
    .num_i  (div_num),
    .den_i  (sym_dur_i),
    .lvl_i  (hold_lvl),
    .ovf_i  (hold_ovf),
    .take_i (div_take),
    .idle_o (div_idle),
    .done_o (div_done),
    .quo_o  (div_quo),
    .lvl_o  (div_lvl),
    .ovf_o  (div_ovf)
  );

  pwsr_expander #(.CNT_W(CNT_W), .SYM_W(SYM_W)) u_exp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(div_done),
    .in_ready_o(exp_ready),
    .quo_i     (div_quo),
    .ovf_i     (div_ovf),
    .lvl_i     (div_lvl),
    .max_i     (max_syms_i),
    .valid_o   (sym_valid_o),
    .data_o    (sym_data_o),
    .ready_i   (sym_ready_i)
  );
endmodule

// File: rtl/pwsr_checker.sv
`timescale 1ns/1ps
module pwsr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             sym_valid_o,
  input logic             sym_ready_i,
  input logic             sym_data_o,
  input logic             lvl_sync,
  input logic [CNT_W-1:0] cnt_hi,
  input logic [CNT_W-1:0] cnt_lo,
  input logic             hold_vld,
  input logic             hold_take,
  input logic [CNT_W-1:0] hold_len
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (!sym_valid_o);
  end

  assert_sat_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_hi == '1) && enable_i && lvl_sync |=> (cnt_hi == '1));

  assert_sat_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_lo == '1) && enable_i && !lvl_sync |=> (cnt_lo == '1));

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o && !sym_ready_i |=> sym_valid_o && $stable(sym_data_o));

  assert_run_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_vld && !hold_take |=> hold_vld && $stable(hold_len));

  assert_idle_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !$rose(hold_vld));
endmodule

bind pw_symbol_rx pwsr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .sym_valid_o(sym_valid_o),
  .sym_ready_i(sym_ready_i),
  .sym_data_o (sym_data_o),
  .lvl_sync   (lvl_sync),
  .cnt_hi     (run_cnt[1]),
  .cnt_lo     (run_cnt[0]),
  .hold_vld   (hold_vld),
  .hold_take  (hold_take),
  .hold_len   (hold_len)
);

// File: tb/tb_pw_symbol_rx.sv
`timescale 1ns/1ps
module tb_pw_symbol_rx;
  localparam int PRE_W = 8;
  localparam int CNT_W = 16;
  localparam int SYM_W = 8;
  localparam int NVEC  = 10;
  localparam int RXMAX = 4096;

  // fields: prescale, duration, max, level, cycles, requirement number
  localparam int VEC [NVEC][6] = '{
    '{0, 100, 40, 1, 300,  4},
    '{0, 100, 40, 0, 249,  4},
    '{0, 100, 40, 1, 250,  4},
    '{0, 100, 40, 0, 20,   5},
    '{3, 25,  40, 1, 400,  2},
    '{3, 25,  40, 0, 399,  2},
    '{9, 10,  40, 1, 1000, 2},
    '{0, 7,   40, 0, 70,   4},
    '{0, 10,  40, 1, 1000, 6},
    '{0, 0,   40, 0, 50,   6}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enable_i = 1'b0;
  logic             line_i = 1'b0;
  logic [PRE_W-1:0] prescale_i = '0;
  logic [CNT_W-1:0] sym_dur_i = '0;
  logic [SYM_W-1:0] max_syms_i = 8'd1;
  logic             sym_valid_o, sym_data_o;
  logic             sym_ready_i = 1'b1;

  int  n_tests = 0, n_fail = 0;
  bit  finished = 1'b0;
  int  rx_n = 0;
  bit  rx_lvl [RXMAX];

  always #2 clk_i = ~clk_i;

  pw_symbol_rx #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SYM_W(SYM_W)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .line_i     (line_i),
    .prescale_i (prescale_i),
    .sym_dur_i  (sym_dur_i),
    .max_syms_i (max_syms_i),
    .sym_valid_o(sym_valid_o),
    .sym_data_o (sym_data_o),
    .sym_ready_i(sym_ready_i)
  );

  always @(negedge clk_i) begin
    if (rst_ni && sym_valid_o && sym_ready_i && rx_n < RXMAX) begin
      rx_lvl[rx_n] = sym_data_o;
      rx_n++;
    end
  end

  function automatic string req_name(int r);
    case (r)
      2: return "R2";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R?";
    endcase
  endfunction

  function automatic int exp_syms(int p, int d, int m, int n);
    int ticks, q;
    ticks = n / (p + 1);
    if (ticks >= 65535 || d == 0) return m;
    q = (ticks + d / 2) / d;
    if (q == 0) q = 1;
    if (q > m) q = m;
    return q;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Hold line at lvl for n cycles; called just after a rising edge.
  task automatic drive(bit lvl, int n);
    line_i = lvl;
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic setup(int p, int d, int m, bit idle_lvl);
    enable_i   = 1'b0;
    prescale_i = PRE_W'(p);
    sym_dur_i  = CNT_W'(d);
    max_syms_i = SYM_W'(m);
    drive(idle_lvl, 10);
    enable_i = 1'b1;
    drive(idle_lvl, 10);  // partial run, discarded with its edge (R10)
  endtask

  task automatic check_levels(string req, int base, int n, bit lvl);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rx_lvl[base + i] != lvl) bad++;
    check(bad == 0, req, "symbol levels wrong count", bad, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base, e;
    repeat (5) @(posedge clk_i);
    #1;
    check(sym_valid_o == 1'b0, "R1", "valid during reset", sym_valid_o, 0);
    rst_ni = 1'b1;
    drive(1'b0, 5);
    check(sym_valid_o == 1'b0, "R1", "valid after reset", sym_valid_o, 0);

    // Table of single runs
    for (int v = 0; v < NVEC; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], !VEC[v][3][0]);
      base = rx_n;
      drive(VEC[v][3][0], VEC[v][4]);
      drive(!VEC[v][3][0], 300);
      e = exp_syms(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][4]);
      check(rx_n - base == e, req_name(VEC[v][5]), $sformatf("vec %0d symbol count (R10 first run dropped)", v),
            rx_n - base, e);
      check_levels("R7", base, rx_n - base, VEC[v][3][0]);
    end

    // R7: ordering over mixed runs
    setup(0, 100, 40, 1'b0);
    base = rx_n;
    drive(1'b1, 300);
    drive(1'b0, 200);
    drive(1'b1, 100);
    drive(1'b0, 300);
    check(rx_n - base == 6, "R7", "mixed sequence count", rx_n - base, 6);
    check_levels("R7", base, 3, 1'b1);
    check_levels("R7", base + 3, 2, 1'b0);
    check_levels("R7", base + 5, 1, 1'b1);

    // R8 / R9: stalled output, fourth run dropped
    setup(0, 100, 40, 1'b0);
    sym_ready_i = 1'b0;
    base = rx_n;
    drive(1'b1, 300);
    drive(1'b0, 500);
    drive(1'b1, 200);
    drive(1'b0, 400);
    drive(1'b1, 100);
    check(sym_valid_o == 1'b1, "R8", "valid held while stalled", sym_valid_o, 1);
    check(sym_data_o == 1'b1, "R8", "data held while stalled", sym_data_o, 1);
    check(rx_n - base == 0, "R8", "no symbol taken while stalled", rx_n - base, 0);
    sym_ready_i = 1'b1;
    drive(1'b1, 300);
    enable_i = 1'b0;
    check(rx_n - base == 10, "R9", "three buffered runs only", rx_n - base, 10);
    check_levels("R9", base, 3, 1'b1);
    check_levels("R9", base + 3, 5, 1'b0);
    check_levels("R9", base + 8, 2, 1'b1);

    // R3: counter saturation; a wrapped count would give 4
    setup(0, 1000, 100, 1'b0);
    base = rx_n;
    drive(1'b1, 70000);
    drive(1'b0, 300);
    check(rx_n - base == 100, "R3", "overflow run count", rx_n - base, 100);
    check_levels("R3", base, rx_n - base, 1'b1);

    // R3: just below saturation is a normal run
    setup(0, 1000, 100, 1'b0);
    base = rx_n;
    drive(1'b1, 65000);
    drive(1'b0, 300);
    check(rx_n - base == 65, "R3", "long run below saturation", rx_n - base, 65);

    // R10: disabled, toggling line gives nothing
    enable_i = 1'b0;
    prescale_i = '0;
    sym_dur_i = CNT_W'(10);
    max_syms_i = SYM_W'(40);
    base = rx_n;
    for (int k = 0; k < 6; k++) drive(k[0], 100);
    drive(1'b0, 100);
    check(rx_n - base == 0, "R10", "symbols while disabled", rx_n - base, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule